// File: doc/BRIEF.md
# Parallel-Input Serializer with Change Detect

This block sends a snapshot of a parallel input bus, or a word written by the host, out on an SPI-style serial line: a serial clock, one data output and an active-low chip select. A select bit chooses the source. The pin snapshot is refreshed on every system clock edge. The alternate word changes only on a host write. The frame is 4 to 16 bits long, taken from the low bits of the selected word and sent most significant bit first.

As a slave, the block follows an external master's clock and chip select with clock polarity 0 and phase 0. It never starts a frame on its own. As a master, it starts a frame only when the trigger input is high and the selected data differs from the last frame sent. A copy of the last frame is kept in a comparison register, which the host can read.

In slave mode the comparison drives a single-cycle master-trigger output, raised once per detected change. A rising edge on the trigger input can also be relayed to that output. Several devices can be chained this way.

Top module: `pin_serializer`

## Requirements
- R1: After reset, sout, sck_out and mtrig are 0, cs_out_n is 1, and comp_q is 0.
- R2: With cfg_src_alt = 0 the frame comes from the pin snapshot. With cfg_src_alt = 1 it comes from the alternate word, which is loaded from host_wdata only on a cycle where host_wr = 1.
- R3: The frame length is cfg_len clamped to the range 4..16. A frame carries the low N bits of the source, most significant bit first on sout.
- R4: The frame value is captured when the frame starts: in slave mode when chip select falls, in master mode when the frame is launched. The pins may change during the frame without changing the bits shifted out.
- R5: When the N-th sampling edge of the serial clock has passed, comp_q takes the low N bits of the frame, with the upper bits zero. comp_q changes at no other time.
- R6: In slave mode with cfg_chg_en = 1, a difference between the low N bits of the selected source and of comp_q gives exactly one mtrig pulse. No further pulse is given until a frame completes. With cfg_chg_en = 0, a difference gives no pulse.
- R7: In slave mode with cfg_relay_en = 1, each rising edge of trig_in gives one mtrig pulse. With cfg_relay_en = 0, trig_in gives no pulse.
- R8: In slave mode cs_out_n stays 1. In master mode mtrig stays 0.
- R9: In master mode, while idle, trig_in = 1 together with a difference in the low N bits launches a frame. cs_out_n falls, and sck_out idles low and toggles every SCK_HALF (at least 2) system clocks. Data is sampled on the rising edge and shifted on the falling edge.
- R10: In master mode, no frame starts while trig_in = 0. No frame starts while the selected data equals the last frame, even with trig_in held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | DW | Parallel input pins |
| host_wr | input | 1 | Host write strobe for the alternate word |
| host_wdata | input | DW | Host write data |
| cfg_src_alt | input | 1 | Source select: 0 pins, 1 alternate word |
| cfg_master | input | 1 | 1 master mode, 0 slave mode |
| cfg_chg_en | input | 1 | Enable for the change-detect trigger |
| cfg_relay_en | input | 1 | Enable for the trigger relay |
| cfg_len | input | LW | Requested frame length in bits |
| trig_in | input | 1 | Hardware trigger input |
| sck_in | input | 1 | Serial clock from an external master |
| cs_in_n | input | 1 | Chip select from an external master, active low |
| sout | output | 1 | Serial data output |
| sck_out | output | 1 | Serial clock driven in master mode |
| cs_out_n | output | 1 | Chip select driven in master mode, active low |
| mtrig | output | 1 | Single-cycle master-trigger pulse |
| comp_q | output | DW | Copy of the last frame sent |

## Verification
The assertions are checked on every cycle and cover four properties:
- mtrig never pulses in master mode.
- sck_out stays low while chip select is inactive.
- A slave never pulls its own chip select.
- comp_q changes only on a frame-completion pulse, and that pulse lasts one cycle.

Only the bench's scenarios can show the bit order, the clamped frame length, the capture of the value at frame start, and the single pulse per change. The same holds for relayed triggers and the gating of master launches on trigger and difference.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int MIN_BITS = 4;
  typedef enum logic [1:0] {M_IDLE, M_RUN, M_LAST} mst_e;
endpackage

// File: rtl/pss_source.sv
module pss_source #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_in,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          src_alt,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] comp,
  output logic [DW-1:0] data_m,
  output logic          diff
);
  logic [DW-1:0] pins_q, alt_q, alt_d;

  always_comb begin
    alt_d = alt_q;
    if (host_wr) alt_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
      alt_q  <= '0;
    end else begin
      pins_q <= pin_in;
      alt_q  <= alt_d;
    end
  end

  assign data_m = (src_alt ? alt_q : pins_q) & mask;
  assign diff   = data_m != (comp & mask);
endmodule

// File: rtl/pss_shifter.sv
module pss_shifter #(
  parameter int DW = 16,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          sample,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] data,
  output logic          sout,
  output logic [DW-1:0] comp,
  output logic          done
);
  logic [DW-1:0] sh_q, sh_d, frame_q, frame_d, comp_q, comp_d;
  logic [LW-1:0] cnt_q, cnt_d, amt;
  logic          done_d;

  assign amt = LW'(DW) - len;

  always_comb begin
    sh_d    = sh_q;
    frame_d = frame_q;
    cnt_d   = cnt_q;
    comp_d  = comp_q;
    done_d  = 1'b0;
    if (load) begin
      frame_d = data;
      sh_d    = data << amt;
      cnt_d   = '0;
    end else begin
      if (shift) sh_d = sh_q << 1;
      if (sample && cnt_q != len) begin
        cnt_d = cnt_q + LW'(1);
        if (cnt_q + LW'(1) == len) begin
          done_d = 1'b1;
          comp_d = frame_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      frame_q <= '0;
      cnt_q   <= '0;
      comp_q  <= '0;
      done    <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
      comp_q  <= comp_d;
      done    <= done_d;
    end
  end

  assign sout = sh_q[DW-1];
  assign comp = comp_q;
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic trig_in,
  input  logic diff,
  input  logic done,
  input  logic sck_in,
  input  logic cs_in_n,
  output logic load,
  output logic shift,
  output logic sample,
  output logic cs_out_n,
  output logic sck_out
);
  localparam int DIVW = $clog2(HALF + 1);

  logic [2:0]      s_sck, s_cs;
  mst_e            st_q, st_d;
  logic [DIVW-1:0] div_q, div_d;
  logic            sck_q, sck_d, cs_q, cs_d;
  logic            m_load, m_shift, m_sample;
  logic            sl_rise, sl_fall, sl_csf, sl_sel, toggle;

  assign sl_rise = s_sck[1] & ~s_sck[2];
  assign sl_fall = ~s_sck[1] & s_sck[2];
  assign sl_csf  = ~s_cs[1] & s_cs[2];
  assign sl_sel  = ~s_cs[1];
  assign toggle  = div_q == DIVW'(HALF - 1);

  always_comb begin
    st_d     = st_q;
    div_d    = div_q;
    sck_d    = sck_q;
    cs_d     = cs_q;
    m_load   = 1'b0;
    m_shift  = 1'b0;
    m_sample = 1'b0;
    case (st_q)
      M_IDLE: begin
        sck_d = 1'b0;
        cs_d  = 1'b1;
        div_d = '0;
        if (cfg_master && trig_in && diff) begin
          st_d   = M_RUN;
          cs_d   = 1'b0;
          m_load = 1'b1;
        end
      end
      default: begin
        if (done) st_d = M_LAST;
        if (toggle) begin
          div_d = '0;
          if (st_q == M_LAST) begin
            sck_d = 1'b0;
            cs_d  = 1'b1;
            st_d  = M_IDLE;
          end else begin
            sck_d    = ~sck_q;
            m_sample = ~sck_q;
            m_shift  = sck_q;
          end
        end else begin
          div_d = div_q + DIVW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck <= 3'b000;
      s_cs  <= 3'b111;
      st_q  <= M_IDLE;
      div_q <= '0;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      s_sck <= {s_sck[1:0], sck_in};
      s_cs  <= {s_cs[1:0], cs_in_n};
      st_q  <= st_d;
      div_q <= div_d;
      sck_q <= sck_d;
      cs_q  <= cs_d;
    end
  end

  assign load     = cfg_master ? m_load   : sl_csf;
  assign shift    = cfg_master ? m_shift  : (sl_fall & sl_sel);
  assign sample   = cfg_master ? m_sample : (sl_rise & sl_sel);
  assign cs_out_n = cs_q;
  assign sck_out  = sck_q;
endmodule

// File: rtl/pss_trig.sv
module pss_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic chg_en,
  input  logic relay_en,
  input  logic diff,
  input  logic trig_in,
  input  logic done,
  output logic mtrig
);
  logic trig_q, fired_q, fired_d, mtrig_d, chg_ev, relay_ev;

  assign chg_ev   = ~cfg_master & chg_en & diff & ~fired_q & ~done;
  assign relay_ev = ~cfg_master & relay_en & trig_in & ~trig_q;

  always_comb begin
    fired_d = fired_q;
    if (done)        fired_d = 1'b0;
    else if (chg_ev) fired_d = 1'b1;
    mtrig_d = chg_ev | relay_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      fired_q <= 1'b0;
      mtrig   <= 1'b0;
    end else begin
      trig_q  <= trig_in;
      fired_q <= fired_d;
      mtrig   <= mtrig_d;
    end
  end
endmodule

// File: rtl/pin_serializer.sv
module pin_serializer
  import pss_pkg::*;
#(
  parameter int DW   = 16,
  parameter int HALF = 2,
  localparam int LW  = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_in,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          cfg_src_alt,
  input  logic          cfg_master,
  input  logic          cfg_chg_en,
  input  logic          cfg_relay_en,
  input  logic [LW-1:0] cfg_len,
  input  logic          trig_in,
  input  logic          sck_in,
  input  logic          cs_in_n,
  output logic          sout,
  output logic          sck_out,
  output logic          cs_out_n,
  output logic          mtrig,
  output logic [DW-1:0] comp_q
);
  logic [LW-1:0] len_eff;
  logic [DW-1:0] mask, data_m;
  logic          diff, done_w, load_w, shift_w, sample_w;

  always_comb begin
    if (cfg_len < LW'(MIN_BITS))  len_eff = LW'(MIN_BITS);
    else if (cfg_len > LW'(DW))   len_eff = LW'(DW);
    else                          len_eff = cfg_len;
    for (int i = 0; i < DW; i++) mask[i] = LW'(i) < len_eff;
  end

  pss_source #(.DW(DW)) u_src (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .host_wr(host_wr),
    .host_wdata(host_wdata), .src_alt(cfg_src_alt), .mask(mask),
    .comp(comp_q), .data_m(data_m), .diff(diff)
  );

  pss_shifter #(.DW(DW), .LW(LW)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(load_w), .shift(shift_w),
    .sample(sample_w), .len(len_eff), .data(data_m), .sout(sout),
    .comp(comp_q), .done(done_w)
  );

  pss_ctrl #(.HALF(HALF)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .trig_in(trig_in),
    .diff(diff), .done(done_w), .sck_in(sck_in), .cs_in_n(cs_in_n),
    .load(load_w), .shift(shift_w), .sample(sample_w),
    .cs_out_n(cs_out_n), .sck_out(sck_out)
  );

  pss_trig u_trg (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .chg_en(cfg_chg_en),
    .relay_en(cfg_relay_en), .diff(diff), .trig_in(trig_in), .done(done_w),
    .mtrig(mtrig)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_master,
  input logic          cs_out_n,
  input logic          sck_out,
  input logic          mtrig,
  input logic [DW-1:0] comp_q,
  input logic          done
);
  AST_MTRIG_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mtrig |-> $past(!cfg_master)); // R8
  AST_SLAVE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_master) && $past(cs_out_n)) |-> cs_out_n); // R8
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_out_n |-> !sck_out); // R9
  AST_COMP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(comp_q) |-> done); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
endmodule

bind pin_serializer pss_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cs_out_n(cs_out_n),
  .sck_out(sck_out), .mtrig(mtrig), .comp_q(comp_q), .done(done_w)
);

// File: tb/pin_serializer_tb.sv
`timescale 1ns/1ps
module pin_serializer_tb_top;
  localparam int DW = 16;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [DW-1:0] pin_in, host_wdata;
  logic host_wr, cfg_src_alt, cfg_master, cfg_chg_en, cfg_relay_en;
  logic [LW-1:0] cfg_len;
  logic trig_in, sck_in, cs_in_n;
  logic sout, sck_out, cs_out_n, mtrig;
  logic [DW-1:0] comp_q;

  int n_chk = 0, n_fail = 0;
  int mtrig_cnt = 0, cs_falls = 0, mcnt = 0;
  logic [DW-1:0] mbits = '0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pin_serializer #(.DW(DW), .HALF(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .host_wr(host_wr),
    .host_wdata(host_wdata), .cfg_src_alt(cfg_src_alt), .cfg_master(cfg_master),
    .cfg_chg_en(cfg_chg_en), .cfg_relay_en(cfg_relay_en), .cfg_len(cfg_len),
    .trig_in(trig_in), .sck_in(sck_in), .cs_in_n(cs_in_n), .sout(sout),
    .sck_out(sck_out), .cs_out_n(cs_out_n), .mtrig(mtrig), .comp_q(comp_q)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mtrig) mtrig_cnt++;
      if (!cs_out_n && prev_cs) cs_falls++;
      if (sck_out && !prev_sck) begin
        mbits = {mbits[DW-2:0], sout};
        mcnt++;
      end
    end
    prev_sck = sck_out;
    prev_cs  = cs_out_n;
  end

  function automatic int eff_len(input int req);
    if (req < 4) return 4;
    if (req > 16) return 16;
    return req;
  endfunction

  function automatic logic [DW-1:0] len_mask(input int n);
    return (n >= DW) ? '1 : ((DW'(1) << n) - DW'(1));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slave_frame(input int n, input bit chg, input logic [DW-1:0] newp,
                             output logic [DW-1:0] got);
    got = '0;
    cs_in_n = 1'b0;
    wcyc(6);
    for (int i = 0; i < n; i++) begin
      got = {got[DW-2:0], sout};
      if (i == 0 && chg) pin_in = newp;
      sck_in = 1'b1;
      wcyc(6);
      sck_in = 1'b0;
      wcyc(6);
    end
    cs_in_n = 1'b1;
    wcyc(6);
  endtask

  initial begin
    logic [DW-1:0] a, b, v, got, m, d;
    int n, base, cf, req;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; pin_in = '0; host_wr = 0; host_wdata = '0; cfg_src_alt = 0;
    cfg_master = 0; cfg_chg_en = 0; cfg_relay_en = 0; cfg_len = 5'd16;
    trig_in = 0; sck_in = 0; cs_in_n = 1;
    wcyc(3);
    rst_n = 1'b1;
    wcyc(1);
    // R1 reset state
    chk(sout == 0 && sck_out == 0 && mtrig == 0, "R1", {sout, sck_out, mtrig}, 0);
    chk(cs_out_n == 1, "R1", cs_out_n, 1);
    chk(comp_q == 0, "R1", comp_q, 0);

    // R6 first nonzero value is a change; one pulse only
    a = DW'($urandom) | 16'h8001;
    cfg_chg_en = 1; pin_in = a;
    base = mtrig_cnt;
    wcyc(20);
    chk(mtrig_cnt - base == 1, "R6", mtrig_cnt - base, 1);

    // R2 R3 R4 R5 slave frame from pins, pins change mid-frame
    b = a ^ 16'h0F0F;
    base = mtrig_cnt;
    slave_frame(16, 1, b, got);
    chk(got == a, "R4", got, a);
    chk(comp_q == a, "R5", comp_q, a);
    wcyc(10);
    chk(mtrig_cnt - base == 1, "R6", mtrig_cnt - base, 1);

    // R2 R3 R5 random alternate-source frames with random lengths
    cfg_src_alt = 1;
    for (int k = 0; k < 6; k++) begin
      req = $urandom_range(4, 16);
      v = DW'($urandom);
      cfg_len = LW'(req);
      @(negedge clk); host_wr = 1; host_wdata = v;
      @(negedge clk); host_wr = 0; host_wdata = ~v;
      pin_in = DW'($urandom);
      wcyc(3);
      m = len_mask(req);
      slave_frame(req, 0, '0, got);
      chk((got & m) == (v & m), "R2", got & m, v & m);
      chk(comp_q == (v & m), "R5", comp_q, v & m);
    end

    // R3 length clamp below 4 and above 16
    for (int k = 0; k < 2; k++) begin
      req = (k == 0) ? 2 : 20;
      n = eff_len(req);
      v = DW'($urandom);
      cfg_len = LW'(req);
      @(negedge clk); host_wr = 1; host_wdata = v;
      @(negedge clk); host_wr = 0;
      wcyc(3);
      m = len_mask(n);
      slave_frame(n, 0, '0, got);
      chk((got & m) == (v & m), "R3", got & m, v & m);
      chk(comp_q == (v & m), "R3", comp_q, v & m);
    end

    // R6 disabled change detect gives no pulse
    cfg_chg_en = 0; cfg_src_alt = 0; cfg_len = 5'd16;
    base = mtrig_cnt;
    pin_in = comp_q ^ 16'h1234;
    wcyc(20);
    chk(mtrig_cnt == base, "R6", mtrig_cnt - base, 0);

    // R7 trigger relay enabled and disabled
    cfg_relay_en = 1;
    base = mtrig_cnt;
    trig_in = 1; wcyc(5); trig_in = 0; wcyc(10);
    chk(mtrig_cnt - base == 1, "R7", mtrig_cnt - base, 1);
    cfg_relay_en = 0;
    base = mtrig_cnt;
    trig_in = 1; wcyc(5); trig_in = 0; wcyc(10);
    chk(mtrig_cnt == base, "R7", mtrig_cnt - base, 0);
    // R8 slave never pulled its own chip select
    chk(cs_falls == 0, "R8", cs_falls, 0);

    // R9 R10 master mode
    cfg_master = 1; cfg_chg_en = 1; cfg_relay_en = 1; cfg_len = 5'd8;
    for (int k = 0; k < 4; k++) begin
      m = len_mask(8);
      d = (DW'($urandom) & ~m) | ((comp_q ^ DW'($urandom_range(1, 255))) & m);
      pin_in = d;
      base = mtrig_cnt; cf = cs_falls;
      wcyc(30);
      chk(cs_falls == cf, "R10", cs_falls - cf, 0);
      mbits = '0; mcnt = 0;
      trig_in = 1;
      wcyc(150);
      chk(cs_falls - cf == 1, "R9", cs_falls - cf, 1);
      chk(mcnt == 8 && (mbits & m) == (d & m), "R9", mbits & m, d & m);
      chk(comp_q == (d & m), "R5", comp_q, d & m);
      chk(cs_out_n == 1 && sck_out == 0, "R9", {cs_out_n, sck_out}, 2'b10);
      chk(mtrig_cnt == base, "R8", mtrig_cnt - base, 0);
      trig_in = 0;
      wcyc(4);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule